// File: doc/BRIEF.md
# Flash Erase-Block Controller with Boot Protection

This controller erases parallel NOR flash one erase block at a time. A request gives an address and a mode. In single mode the address must be the first byte of an erase block. In range mode the controller erases every block from the block that holds the start address up to, but not including, the end address. Block boundaries come from a region table on input ports. Each region has a base address, an end address and a block size that is a power of two. Regions may use different block sizes, so a range can cross from small blocks into large ones.

Before any command reaches the flash, the controller checks the request. It refuses erases that would touch the boot block (the first block of region 0) while protection is enabled. It also refuses addresses that fall outside every region, and single-mode addresses that are not aligned to a block. For each accepted block it does the following:

- raises the program supply,
- writes the two-cycle erase sequence,
- polls the status byte until the ready bit appears or a timeout expires,
- drops the supply,
- writes a status clear and then a reset command,
- reports a result code decoded from the last status byte.

Top module: `flash_block_eraser`

## Requirements
- R1: For an address A, the first valid region i (index below `rgn_count`, lowest index first) with base <= A < end is used. The block start is base + floor((A - base) / 2^lgsz) * 2^lgsz, and the block end is the block start plus 2^lgsz. If no region holds A, the request finishes with result 7 and no flash cycle.
- R2: In single mode, an address that lies in a region but differs from its block start finishes with result 1, and no flash cycle is issued.
- R3: While protection is on, a request finishes with result 2 and no flash cycle in two cases: the start address lies in [base0, base0 + 2^lgsz0), or `rgn_count` is 0. This check comes before the R1 and R2 checks.
- R4: Protection is on after reset. A one-cycle pulse on `prot_off` turns it off, and a pulse on `prot_on` turns it back on. If both are high together, `prot_on` wins.
- R5: Each block erase writes 0x20 and then 0xD0 to the block start, in two consecutive cycles.
- R6: After the confirm, the status byte is read at the block start once per cycle. Reading stops when bit 7 is set, or after TIMEOUT reads. `fl_vpp` is high from the 0x20 write through the last status read, and low otherwise.
- R7: After polling, 0x50 and then 0xFF are written to the block start in consecutive cycles. The result comes from the last status byte, first match wins: bit 1 gives 3 (locked), bit 3 gives 4 (low voltage), bit 4 or bit 5 gives 5 (program/erase failure), bit 7 clear gives 6 (timeout), and otherwise 0.
- R8: Range mode erases, in order, the block holding the start address and then each following block found by jumping to the current block end. It stops once the next address is at or above the end address. A nonzero result for any block ends the run with that result.
- R9: A range request whose start is at or above its end finishes with result 0 and no flash cycle. A range whose next block lies outside every region finishes with result 7.
- R10: `busy` rises in the cycle after a request is accepted. It stays high through the 0xFF write, or through the rejection decision. `done` pulses for one cycle as `busy` falls, and `result` is valid from that cycle on. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_off | input | 1 | Pulse: disable boot-block protection |
| prot_on | input | 1 | Pulse: enable boot-block protection |
| req_valid | input | 1 | Erase request, taken while idle |
| req_range | input | 1 | 0 = single block, 1 = range |
| req_addr | input | AW | Block address or range start |
| req_end | input | AW | Range end (exclusive) |
| rgn_count | input | CW | Number of valid regions |
| rgn_base | input | NREG*AW | Region base addresses, region i at bits i*AW |
| rgn_end | input | NREG*AW | Region end addresses (exclusive) |
| rgn_lgsz | input | NREG*LW | log2 of region block size |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Completion code (see R1-R3, R7) |
| fl_addr | output | AW | Flash address |
| fl_we | output | 1 | Flash command write strobe |
| fl_wdata | output | 8 | Flash command byte |
| fl_re | output | 1 | Flash status read strobe |
| fl_rdata | input | 8 | Flash status byte, sampled while `fl_re` is high |
| fl_vpp | output | 1 | Program supply enable |

## Verification
The assertions check the command ordering on every cycle. A 0x20 write must be followed by a 0xD0 write to the same address, and a 0x50 write by a 0xFF write. The supply must be off before the clear, flash activity may happen only while busy, the poll may not run past the timeout, and `done` may come only as `busy` falls. Several behaviours depend on addresses and the region table, so only the bench scenarios can show them. These are the block-start arithmetic across regions of different sizes, the order of the rejection checks, the protection toggle, the mapping of status bits to result codes, and the stepping of range mode across a region boundary and its early stop.

// File: rtl/flash_block_eraser.sv
module flash_block_eraser #(
  parameter int AW      = 24,
  parameter int NREG    = 4,
  parameter int CW      = $clog2(NREG + 1),
  parameter int LW      = $clog2(AW),
  parameter int TIMEOUT = 75_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_off,
  input  logic              prot_on,
  input  logic              req_valid,
  input  logic              req_range,
  input  logic [AW-1:0]     req_addr,
  input  logic [AW-1:0]     req_end,
  input  logic [CW-1:0]     rgn_count,
  input  logic [NREG*AW-1:0] rgn_base,
  input  logic [NREG*AW-1:0] rgn_end,
  input  logic [NREG*LW-1:0] rgn_lgsz,
  output logic              busy,
  output logic              done,
  output logic [2:0]        result,
  output logic [AW-1:0]     fl_addr,
  output logic              fl_we,
  output logic [7:0]        fl_wdata,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata,
  output logic              fl_vpp
);

  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_CMD, S_CONF, S_POLL, S_CLR, S_RST
  } st_t;

  st_t           st;
  logic          prot_en, range_m, first;
  logic [AW-1:0] cur, lim, blk;
  logic [AW:0]   nxt;
  logic [7:0]    stat;
  logic [TW-1:0] tcnt;

  logic          hit;
  logic [AW-1:0] bs;
  logic [AW:0]   be;

  always_comb begin
    hit = 1'b0;
    bs  = '1;
    be  = '1;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (CW'(i) < rgn_count &&
          cur >= rgn_base[i*AW +: AW] && cur < rgn_end[i*AW +: AW]) begin
        hit = 1'b1;
        bs  = rgn_base[i*AW +: AW] +
              (((cur - rgn_base[i*AW +: AW]) >> rgn_lgsz[i*LW +: LW]) << rgn_lgsz[i*LW +: LW]);
        be  = {1'b0, bs} + ((AW+1)'(1) << rgn_lgsz[i*LW +: LW]);
      end
    end
  end

  wire [AW:0] boot_lo = {1'b0, rgn_base[AW-1:0]};
  wire [AW:0] boot_hi = boot_lo + ((AW+1)'(1) << rgn_lgsz[LW-1:0]);
  wire        in_boot = ({1'b0, cur} >= boot_lo) && ({1'b0, cur} < boot_hi);
  wire        refuse  = prot_en && (rgn_count == '0 || in_boot);

  logic [2:0] ecode;
  always_comb begin
    if (stat[1])                ecode = 3'd3;
    else if (stat[3])           ecode = 3'd4;
    else if (stat[4] | stat[5]) ecode = 3'd5;
    else if (!stat[7])          ecode = 3'd6;
    else                        ecode = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      prot_en <= 1'b1;
      range_m <= 1'b0;
      first   <= 1'b0;
      cur     <= '0;
      lim     <= '0;
      blk     <= '0;
      nxt     <= '0;
      stat    <= '0;
      tcnt    <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      if (prot_on)       prot_en <= 1'b1;
      else if (prot_off) prot_en <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cur     <= req_addr;
          lim     <= req_end;
          range_m <= req_range;
          first   <= 1'b1;
          st      <= S_CHECK;
        end
        S_CHECK: begin
          first <= 1'b0;
          if (range_m && cur >= lim) begin
            st <= S_IDLE; done <= 1'b1; result <= 3'd0;
          end else if (first && refuse) begin
            st <= S_IDLE; done <= 1'b1; result <= 3'd2;
          end else if (!hit) begin
            st <= S_IDLE; done <= 1'b1; result <= 3'd7;
          end else if (!range_m && bs != cur) begin
            st <= S_IDLE; done <= 1'b1; result <= 3'd1;
          end else begin
            blk <= bs;
            nxt <= be;
            st  <= S_CMD;
          end
        end
        S_CMD:  st <= S_CONF;
        S_CONF: begin
          tcnt <= '0;
          st   <= S_POLL;
        end
        S_POLL: begin
          stat <= fl_rdata;
          if (fl_rdata[7] || tcnt == TW'(TIMEOUT - 1)) st <= S_CLR;
          else tcnt <= tcnt + 1'b1;
        end
        S_CLR: st <= S_RST;
        S_RST: begin
          if (ecode != 3'd0 || !range_m || nxt[AW]) begin
            st <= S_IDLE; done <= 1'b1; result <= ecode;
          end else begin
            cur <= nxt[AW-1:0];
            st  <= S_CHECK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign fl_addr = blk;
  assign fl_we   = (st == S_CMD) || (st == S_CONF) || (st == S_CLR) || (st == S_RST);
  assign fl_re   = (st == S_POLL);
  assign fl_vpp  = (st == S_CMD) || (st == S_CONF) || (st == S_POLL);

  always_comb begin
    case (st)
      S_CMD:   fl_wdata = 8'h20;
      S_CONF:  fl_wdata = 8'hD0;
      S_CLR:   fl_wdata = 8'h50;
      S_RST:   fl_wdata = 8'hFF;
      default: fl_wdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/flash_block_eraser_chk.sv
module flash_block_eraser_chk #(
  parameter int AW      = 24,
  parameter int TIMEOUT = 75_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] fl_addr,
  input logic          fl_we,
  input logic [7:0]    fl_wdata,
  input logic          fl_re,
  input logic          fl_vpp
);

  localparam int RW = $clog2(TIMEOUT + 2);
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     rcnt <= '0;
    else if (fl_re) rcnt <= rcnt + 1'b1;
    else            rcnt <= '0;
  end

  a_r5_confirm_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == 8'h20) |=> (fl_we && fl_wdata == 8'hD0 && fl_addr == $past(fl_addr)));

  a_r6_vpp_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fl_vpp |-> busy);

  a_r6_vpp_off_at_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == 8'h50) |-> !fl_vpp);

  a_r6_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> (rcnt < RW'(TIMEOUT)));

  a_r7_reset_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == 8'h50) |=> (fl_we && fl_wdata == 8'hFF && fl_addr == $past(fl_addr)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re));

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind flash_block_eraser flash_block_eraser_chk #(.AW(AW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fl_addr(fl_addr),
  .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_re(fl_re), .fl_vpp(fl_vpp)
);

// File: tb/flash_block_eraser_tb.sv
module flash_block_eraser_tb;
  localparam int AW = 16, NREG = 3, CW = 2, LW = 4, TMO = 20;

  logic clk = 0, rst_n = 0;
  logic prot_off = 0, prot_on = 0, req_valid = 0, req_range = 0;
  logic [AW-1:0] req_addr = '0, req_end = '0;
  logic [CW-1:0] rgn_count = 2'd3;
  logic [NREG*AW-1:0] rgn_base = {16'h2400, 16'h0400, 16'h0000};
  logic [NREG*AW-1:0] rgn_end  = {16'h4400, 16'h2400, 16'h0400};
  logic [NREG*LW-1:0] rgn_lgsz = {4'd13, 4'd12, 4'd8};
  logic busy, done, fl_we, fl_re, fl_vpp;
  logic [2:0] result;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  always #10 clk = ~clk;

  flash_block_eraser #(.AW(AW), .NREG(NREG), .CW(CW), .LW(LW), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .prot_off(prot_off), .prot_on(prot_on),
    .req_valid(req_valid), .req_range(req_range), .req_addr(req_addr), .req_end(req_end),
    .rgn_count(rgn_count), .rgn_base(rgn_base), .rgn_end(rgn_end), .rgn_lgsz(rgn_lgsz),
    .busy(busy), .done(done), .result(result), .fl_addr(fl_addr), .fl_we(fl_we),
    .fl_wdata(fl_wdata), .fl_re(fl_re), .fl_rdata(fl_rdata), .fl_vpp(fl_vpp));

  // flash model
  logic [7:0]    log_d [0:63];
  logic [AW-1:0] log_a [0:63];
  int nlog = 0, nread = 0, rdcnt = 0, ready_after = 0;
  logic never = 0, clr = 0;
  logic [7:0] errb = 8'h00;

  assign fl_rdata = (!never && rdcnt >= ready_after) ? (8'h80 | errb) : 8'h00;

  always @(posedge clk) begin
    if (clr) begin
      nlog <= 0; nread <= 0; rdcnt <= 0;
    end else begin
      if (fl_we && nlog < 64) begin
        log_d[nlog] <= fl_wdata;
        log_a[nlog] <= fl_addr;
        nlog <= nlog + 1;
        if (fl_wdata == 8'hD0) rdcnt <= 0;
      end
      if (fl_re) begin
        nread <= nread + 1;
        rdcnt <= rdcnt + 1;
      end
    end
  end

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_req(bit rng, logic [AW-1:0] a, logic [AW-1:0] e);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    req_valid = 1; req_range = rng; req_addr = a; req_end = e;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk); n++;
    end
    chk(req, "done seen", int'(done), 1);
  endtask

  task automatic run(string req, bit rng, logic [AW-1:0] a, logic [AW-1:0] e,
                     int exp_res, int exp_blocks);
    start_req(rng, a, e);
    wait_done(req);
    chk(req, "result", int'(result), exp_res);
    chk(req, "write count", nlog, 4 * exp_blocks);
  endtask

  task automatic chk_blk(string req, int k, logic [AW-1:0] a);
    chk(req, "cmd", int'(log_d[4*k]), 8'h20);
    chk(req, "confirm", int'(log_d[4*k+1]), 8'hD0);
    chk(req, "clear", int'(log_d[4*k+2]), 8'h50);
    chk(req, "reset", int'(log_d[4*k+3]), 8'hFF);
    for (int j = 0; j < 4; j++) chk(req, "block addr", int'(log_a[4*k+j]), int'(a));
  endtask

  task automatic pulse_prot(bit off);
    @(negedge clk);
    if (off) prot_off = 1; else prot_on = 1;
    @(negedge clk); prot_off = 0; prot_on = 0;
  endtask

  task automatic t_reset;
    chk("R10", "busy at reset", int'(busy), 0);
    chk("R10", "done at reset", int'(done), 0);
    chk("R6", "vpp at reset", int'(fl_vpp), 0);
    chk("R10", "we at reset", int'(fl_we), 0);
  endtask

  task automatic t_single_ok;
    ready_after = 3; never = 0; errb = 0;
    start_req(0, 16'h1400, 16'h0);
    chk("R10", "busy after accept", int'(busy), 1);
    wait_done("R5");
    chk("R7", "result ok", int'(result), 0);
    chk("R5", "writes", nlog, 4);
    chk_blk("R5", 0, 16'h1400);
    chk("R6", "poll reads", nread, 4);
    ready_after = 0;
  endtask

  task automatic t_rejects;
    run("R2", 0, 16'h1401, 16'h0, 1, 0);
    run("R2", 0, 16'h0480, 16'h0, 1, 0);
    run("R1", 0, 16'h5000, 16'h0, 7, 0);
    run("R1", 0, 16'h2400, 16'h0, 0, 1);
    chk_blk("R1", 0, 16'h2400);
  endtask

  task automatic t_protect;
    run("R3", 0, 16'h0000, 16'h0, 2, 0);
    run("R3", 0, 16'h0080, 16'h0, 2, 0);
    run("R3", 0, 16'h0100, 16'h0, 0, 1);
    pulse_prot(1);
    run("R4", 0, 16'h0000, 16'h0, 0, 1);
    chk_blk("R4", 0, 16'h0000);
    pulse_prot(0);
    run("R4", 0, 16'h0000, 16'h0, 2, 0);
    @(negedge clk); prot_off = 1; prot_on = 1;
    @(negedge clk); prot_off = 0; prot_on = 0;
    run("R4", 0, 16'h0000, 16'h0, 2, 0);
    rgn_count = 0;
    run("R3", 0, 16'h1400, 16'h0, 2, 0);
    pulse_prot(1);
    run("R1", 0, 16'h1400, 16'h0, 7, 0);
    pulse_prot(0);
    rgn_count = 3;
  endtask

  task automatic t_status;
    errb = 8'h02; run("R7", 0, 16'h1400, 16'h0, 3, 1);
    errb = 8'h0A; run("R7", 0, 16'h1400, 16'h0, 3, 1);
    errb = 8'h08; run("R7", 0, 16'h1400, 16'h0, 4, 1);
    errb = 8'h20; run("R7", 0, 16'h1400, 16'h0, 5, 1);
    errb = 8'h10; run("R7", 0, 16'h1400, 16'h0, 5, 1);
    errb = 8'h00; never = 1;
    run("R6", 0, 16'h1400, 16'h0, 6, 1);
    chk("R6", "timeout reads", nread, TMO);
    chk_blk("R7", 0, 16'h1400);
    never = 0;
  endtask

  task automatic t_range;
    run("R8", 1, 16'h0200, 16'h2400, 0, 4);
    chk_blk("R8", 0, 16'h0200);
    chk_blk("R8", 1, 16'h0300);
    chk_blk("R8", 2, 16'h0400);
    chk_blk("R8", 3, 16'h1400);
    run("R8", 1, 16'h0250, 16'h0301, 0, 2);
    chk_blk("R8", 1, 16'h0300);
    errb = 8'h20;
    run("R8", 1, 16'h0200, 16'h2400, 5, 1);
    errb = 8'h00;
    run("R9", 1, 16'h0300, 16'h0300, 0, 0);
    run("R9", 1, 16'h0300, 16'h0100, 0, 0);
    run("R3", 1, 16'h0000, 16'h0400, 2, 0);
    run("R9", 1, 16'h5000, 16'h6000, 7, 0);
    run("R9", 1, 16'h2400, 16'h6000, 7, 1);
  endtask

  task automatic t_busy_ignore;
    ready_after = 6;
    start_req(0, 16'h1400, 16'h0);
    @(negedge clk);
    req_valid = 1; req_range = 0; req_addr = 16'h2400;
    @(negedge clk); req_valid = 0;
    wait_done("R10");
    chk("R10", "first result", int'(result), 0);
    chk("R10", "ignored request writes", nlog, 4);
    chk_blk("R10", 0, 16'h1400);
    repeat (4) @(negedge clk);
    chk("R10", "stays idle", int'(busy), 0);
    chk("R10", "no extra writes", nlog, 4);
    ready_after = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single_ok();
    t_rejects();
    t_protect();
    t_status();
    t_range();
    t_busy_ignore();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule